// File: doc/BRIEF.md
# In-Order Issue Controller with Delayed Branch and Load Interlock

This block is the control part of a short in-order pipeline for a fixed-format register machine. Instructions are fetched one per cycle from instruction memory. Each fetched word then passes to an execute slot, where it is decoded and issued. Register-to-register operations complete in that slot. Loads and stores compute their address in execute and then occupy a single memory phase, which holds a request to data memory until the memory answers with ready.

Control transfers are delayed by one instruction. The word right after a jump, or after a taken branch, always issues. The fetch after it comes from the target. There is no squash.

Loads do not stall the machine by themselves. Each load sets a lock bit on its destination register. Only an instruction that reads or overwrites a locked register waits. Independent work keeps flowing while the load is outstanding.

The ALU datapath and the register file sit outside this block. It drives the decoded register fields, the write enables and the program counter of the issuing instruction for them.

Top module: `pipe_ctl`

## Requirements
- R1: While reset is held, the fetch address is 0, nothing issues, no lock bit is set and no data memory request is raised. The first fetch after release is from address 0.
- R2: Word layout is op[31:28], rd[27:23], rs1[22:18], rs2[17:13], imm[12:0]. The opcodes are:
  - 0: no-op
  - 1: reg-reg ALU, which reads rs1 and rs2 and writes rd
  - 2: reg-imm ALU, which reads rs1 and writes rd
  - 3: load, which reads rs1 and writes rd
  - 4: store, which reads rs1 and rs2
  - 5: jump
  - 6: conditional branch, which reads rs1 and is taken when br_cond_i is high in its issue cycle

  Other codes act as no-ops. An ALU instruction raises rf_we_o with rf_waddr_o equal to rd in its issue cycle.
- R3: Without a control transfer, instructions issue in ascending address order, at most one per cycle.
- R4: After a jump or taken branch, the next instruction in memory (the delay slot) issues next. The instruction at imm[PC_W-1:0] follows it. A branch that is not taken continues in sequence.
- R5: An issuing load sets the lock bit of rd. The bit stays set until the memory handshake (request and ready both high) completes that load. In that same cycle ld_we_o is high with ld_waddr_o equal to rd.
- R6: An instruction that touches no locked register issues while a load is outstanding, with no added cycle.
- R7: An instruction whose read register (rs1 or rs2 as used by its opcode, including the store data register) is locked does not issue. It issues in the cycle after the lock clears.
- R8: An instruction whose destination register is locked waits the same way, so that the older load cannot overwrite a younger result.
- R9: Register 0 is never locked, so a load to r0 never stalls a reader of r0. Writes to r0 raise neither rf_we_o nor ld_we_o.
- R10: At most one memory operation is outstanding. dmem_req_o and dmem_we_o stay steady until ready. A second load or store waits until the current one completes, and it may issue in the completion cycle. A store raises dmem_we_o.
- R11: During a stall, the fetch address and the instruction in the execute slot are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | PC_W | Instruction fetch word address |
| imem_rdata_i | input | IW | Instruction word at imem_addr_o, same cycle |
| br_cond_i | input | 1 | Branch condition from the datapath for the issuing branch |
| ex_issue_o | output | 1 | The execute-slot instruction issues this cycle |
| ex_pc_o | output | PC_W | Address of the execute-slot instruction |
| ex_rs1_o | output | REG_W | First source field |
| ex_rs2_o | output | REG_W | Second source field |
| ex_rd_o | output | REG_W | Destination field |
| stall_o | output | 1 | Execute slot held by a lock or by a busy memory phase |
| rf_we_o | output | 1 | ALU result write enable |
| rf_waddr_o | output | REG_W | ALU result register |
| dmem_req_o | output | 1 | Data memory request |
| dmem_we_o | output | 1 | Request is a store |
| dmem_reg_o | output | REG_W | Load destination or store data register |
| dmem_ready_i | input | 1 | Data memory completes the request |
| ld_we_o | output | 1 | Load data write enable |
| ld_waddr_o | output | REG_W | Load data register |
| lock_o | output | NREG | Per-register lock bits |

## Verification
A lock bit that is stuck or never set shows at the ports as an issue that comes too early or never comes. This is visible in the cycle right after the load completes, as a change in the timing of the dependent issue. A wrong fetch register shows as a wrong ex_pc_o on the next issue after a transfer. Because of that, the bench compares the full issue order and the issue cycles against the load write-back cycles. A lost memory phase shows as a handshake count that differs from the number of memory instructions.

// File: rtl/pipe_ctl_pkg.sv
package pipe_ctl_pkg;
  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_ALU    = 4'd1,
    OP_ALUI   = 4'd2,
    OP_LOAD   = 4'd3,
    OP_STORE  = 4'd4,
    OP_JUMP   = 4'd5,
    OP_BRANCH = 4'd6
  } op_e;

  typedef struct packed {
    logic use_rs1;
    logic use_rs2;
    logic wr_rd;
    logic alu_wb;
    logic is_mem;
    logic is_store;
    logic is_jump;
    logic is_branch;
  } ctl_t;

  function automatic ctl_t decode_op(input logic [3:0] op);
    ctl_t c;
    c = '0;
    case (op)
      OP_ALU:    begin c.use_rs1 = 1'b1; c.use_rs2 = 1'b1; c.wr_rd = 1'b1; c.alu_wb = 1'b1; end
      OP_ALUI:   begin c.use_rs1 = 1'b1; c.wr_rd = 1'b1; c.alu_wb = 1'b1; end
      OP_LOAD:   begin c.use_rs1 = 1'b1; c.wr_rd = 1'b1; c.is_mem = 1'b1; end
      OP_STORE:  begin c.use_rs1 = 1'b1; c.use_rs2 = 1'b1; c.is_mem = 1'b1; c.is_store = 1'b1; end
      OP_JUMP:   c.is_jump = 1'b1;
      OP_BRANCH: begin c.use_rs1 = 1'b1; c.is_branch = 1'b1; end
      default:   c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/pipe_fetch.sv
module pipe_fetch #(
  parameter int PC_W = 12,
  parameter int IW   = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  logic            redirect_i,
  input  logic [PC_W-1:0] target_i,
  input  logic [IW-1:0]   imem_rdata_i,
  output logic [PC_W-1:0] pc_o,
  output logic [IW-1:0]   ir_o,
  output logic [PC_W-1:0] ir_pc_o,
  output logic            ir_valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o       <= '0;
      ir_o       <= '0;
      ir_pc_o    <= '0;
      ir_valid_o <= 1'b0;
    end else if (adv_i) begin
      ir_o       <= imem_rdata_i;
      ir_pc_o    <= pc_o;
      ir_valid_o <= 1'b1;
      // the word fetched this cycle is the delay slot; the target comes next
      pc_o       <= redirect_i ? target_i : pc_o + 1'b1;
    end
  end
endmodule

// File: rtl/pipe_scoreboard.sv
module pipe_scoreboard #(
  parameter int REG_W = 5,
  parameter int NREG  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [REG_W-1:0] set_idx_i,
  input  logic             clr_i,
  input  logic [REG_W-1:0] clr_idx_i,
  output logic [NREG-1:0]  lock_o
);
  assign lock_o[0] = 1'b0;

  for (genvar g = 1; g < NREG; g++) begin : g_lock
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        lock_o[g] <= 1'b0;
      else if (set_i && set_idx_i == REG_W'(g))
        lock_o[g] <= 1'b1;
      else if (clr_i && clr_idx_i == REG_W'(g))
        lock_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/pipe_memstage.sv
module pipe_memstage #(
  parameter int REG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] reg_i,
  input  logic             ready_i,
  output logic             free_o,
  output logic             done_o,
  output logic             req_o,
  output logic             we_o,
  output logic [REG_W-1:0] reg_o
);
  logic valid_q;

  assign free_o = !valid_q || ready_i;
  assign done_o = valid_q && ready_i;
  assign req_o  = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      we_o    <= 1'b0;
      reg_o   <= '0;
    end else if (issue_i) begin
      valid_q <= 1'b1;
      we_o    <= we_i;
      reg_o   <= reg_i;
    end else if (done_o) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pipe_ctl.sv
module pipe_ctl
  import pipe_ctl_pkg::*;
#(
  parameter int PC_W  = 12,
  parameter int REG_W = 5,
  parameter int IMM_W = 13,
  localparam int NREG = 2 ** REG_W,
  localparam int IW   = 4 + 3 * REG_W + IMM_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [PC_W-1:0]  imem_addr_o,
  input  logic [IW-1:0]    imem_rdata_i,
  input  logic             br_cond_i,
  output logic             ex_issue_o,
  output logic [PC_W-1:0]  ex_pc_o,
  output logic [REG_W-1:0] ex_rs1_o,
  output logic [REG_W-1:0] ex_rs2_o,
  output logic [REG_W-1:0] ex_rd_o,
  output logic             stall_o,
  output logic             rf_we_o,
  output logic [REG_W-1:0] rf_waddr_o,
  output logic             dmem_req_o,
  output logic             dmem_we_o,
  output logic [REG_W-1:0] dmem_reg_o,
  input  logic             dmem_ready_i,
  output logic             ld_we_o,
  output logic [REG_W-1:0] ld_waddr_o,
  output logic [NREG-1:0]  lock_o
);
  localparam int OP_LSB  = IW - 4;
  localparam int RD_LSB  = OP_LSB - REG_W;
  localparam int RS1_LSB = RD_LSB - REG_W;
  localparam int RS2_LSB = RS1_LSB - REG_W;

  logic [IW-1:0]    ir;
  logic             ir_valid;
  logic [3:0]       op;
  ctl_t             ctl;
  logic [PC_W-1:0]  br_target;
  logic             redirect;
  logic             lock_hz, mem_hz;
  logic             mem_free, mem_done, mem_issue;

  pipe_fetch #(.PC_W(PC_W), .IW(IW)) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .adv_i        (!stall_o),
    .redirect_i   (redirect),
    .target_i     (br_target),
    .imem_rdata_i (imem_rdata_i),
    .pc_o         (imem_addr_o),
    .ir_o         (ir),
    .ir_pc_o      (ex_pc_o),
    .ir_valid_o   (ir_valid)
  );

  assign op        = ir[IW-1:OP_LSB];
  assign ctl       = decode_op(op);
  assign ex_rd_o   = ir[OP_LSB-1:RD_LSB];
  assign ex_rs1_o  = ir[RD_LSB-1:RS1_LSB];
  assign ex_rs2_o  = ir[RS1_LSB-1:RS2_LSB];
  assign br_target = ir[PC_W-1:0];

  // read-after-load and write-after-load interlock
  assign lock_hz = (ctl.use_rs1 && lock_o[ex_rs1_o]) ||
                   (ctl.use_rs2 && lock_o[ex_rs2_o]) ||
                   (ctl.wr_rd   && lock_o[ex_rd_o]);
  assign mem_hz  = ctl.is_mem && !mem_free;

  assign stall_o    = ir_valid && (lock_hz || mem_hz);
  assign ex_issue_o = ir_valid && !stall_o;
  assign redirect   = ex_issue_o && (ctl.is_jump || (ctl.is_branch && br_cond_i));
  assign mem_issue  = ex_issue_o && ctl.is_mem;

  assign rf_we_o    = ex_issue_o && ctl.alu_wb && (ex_rd_o != '0);
  assign rf_waddr_o = ex_rd_o;

  pipe_memstage #(.REG_W(REG_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (mem_issue),
    .we_i    (ctl.is_store),
    .reg_i   (ctl.is_store ? ex_rs2_o : ex_rd_o),
    .ready_i (dmem_ready_i),
    .free_o  (mem_free),
    .done_o  (mem_done),
    .req_o   (dmem_req_o),
    .we_o    (dmem_we_o),
    .reg_o   (dmem_reg_o)
  );

  assign ld_we_o    = mem_done && !dmem_we_o && (dmem_reg_o != '0);
  assign ld_waddr_o = dmem_reg_o;

  pipe_scoreboard #(.REG_W(REG_W), .NREG(NREG)) u_sb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (mem_issue && !ctl.is_store),
    .set_idx_i (ex_rd_o),
    .clr_i     (ld_we_o),
    .clr_idx_i (ld_waddr_o),
    .lock_o    (lock_o)
  );
endmodule

// File: rtl/pipe_ctl_chk.sv
module pipe_ctl_chk #(
  parameter int PC_W  = 12,
  parameter int REG_W = 5,
  parameter int NREG  = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             stall_i,
  input logic             redirect_i,
  input logic [PC_W-1:0]  target_i,
  input logic [PC_W-1:0]  imem_addr_i,
  input logic [PC_W-1:0]  ex_pc_i,
  input logic             dmem_req_i,
  input logic             dmem_we_i,
  input logic             dmem_ready_i,
  input logic             ld_we_i,
  input logic [REG_W-1:0] ld_waddr_i,
  input logic [NREG-1:0]  lock_i
);
  AST_REDIRECT_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> imem_addr_i == $past(target_i)); // R4

  AST_SEQ_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !redirect_i) |=> imem_addr_i == PC_W'($past(imem_addr_i) + 1'b1)); // R3

  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> ($stable(imem_addr_i) && $stable(ex_pc_i))); // R11

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmem_req_i && !dmem_ready_i) |=> (dmem_req_i && $stable(dmem_we_i))); // R10

  AST_LOAD_WB_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_we_i |-> lock_i[ld_waddr_i]); // R5
endmodule

bind pipe_ctl pipe_ctl_chk #(.PC_W(PC_W), .REG_W(REG_W), .NREG(NREG)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stall_i      (stall_o),
  .redirect_i   (redirect),
  .target_i     (br_target),
  .imem_addr_i  (imem_addr_o),
  .ex_pc_i      (ex_pc_o),
  .dmem_req_i   (dmem_req_o),
  .dmem_we_i    (dmem_we_o),
  .dmem_ready_i (dmem_ready_i),
  .ld_we_i      (ld_we_o),
  .ld_waddr_i   (ld_waddr_o),
  .lock_i       (lock_o)
);

// File: tb/tb_pipe_ctl.sv
module tb_pipe_ctl;
  localparam int PC_W  = 12;
  localparam int REG_W = 5;
  localparam int IMM_W = 13;
  localparam int NREG  = 2 ** REG_W;
  localparam int IW    = 4 + 3 * REG_W + IMM_W;
  localparam int LAT   = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [IW-1:0]    prog [0:31];
  logic [PC_W-1:0]  imem_addr;
  logic [IW-1:0]    imem_rdata;
  logic             br_cond;
  logic             ex_issue, stall, rf_we, dmem_req, dmem_we, ld_we;
  logic             dmem_ready = 1'b0;
  logic [PC_W-1:0]  ex_pc;
  logic [REG_W-1:0] ex_rs1, ex_rs2, ex_rd, rf_waddr, dmem_reg, ld_waddr;
  logic [NREG-1:0]  lock;

  assign imem_rdata = prog[imem_addr[4:0]];
  assign br_cond    = (ex_pc == PC_W'(10));

  pipe_ctl #(.PC_W(PC_W), .REG_W(REG_W), .IMM_W(IMM_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .imem_addr_o(imem_addr), .imem_rdata_i(imem_rdata), .br_cond_i(br_cond),
    .ex_issue_o(ex_issue), .ex_pc_o(ex_pc), .ex_rs1_o(ex_rs1), .ex_rs2_o(ex_rs2),
    .ex_rd_o(ex_rd), .stall_o(stall), .rf_we_o(rf_we), .rf_waddr_o(rf_waddr),
    .dmem_req_o(dmem_req), .dmem_we_o(dmem_we), .dmem_reg_o(dmem_reg),
    .dmem_ready_i(dmem_ready), .ld_we_o(ld_we), .ld_waddr_o(ld_waddr), .lock_o(lock)
  );

  int checks = 0, errors = 0, cyc = 0, hs = 0;
  int exp_q[$];
  int t1 = 0, t3 = 0, t5 = 0, t6 = 0, t14 = 0, t_ld4 = 0, t_ld12 = 0;
  bit chk_store = 0, stall_seen = 0, stall_pend = 0;
  logic [PC_W-1:0] hold_pc, hold_fa;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] enc(input int op, input int rd, input int rs1, input int rs2, input int imm);
    return {op[3:0], rd[REG_W-1:0], rs1[REG_W-1:0], rs2[REG_W-1:0], imm[IMM_W-1:0]};
  endfunction

  task automatic push_exp(input int pc);
    exp_q.push_back(pc);
  endtask

  // data memory responder
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(posedge clk);
      #1;
      if (dmem_ready) begin
        dmem_ready = 1'b0;
        cnt = 0;
      end else if (dmem_req) begin
        if (cnt >= LAT) dmem_ready = 1'b1;
        else cnt++;
      end
    end
  end

  // monitor: pops expected issue order and checks timing relations
  always @(negedge clk) begin
    int pc, e;
    if (rst_ni) begin
      if (stall_pend) begin
        chk(ex_pc == hold_pc && imem_addr == hold_fa, "R11", "held pc", int'(ex_pc), int'(hold_pc));
        stall_pend = 0;
      end
      if (stall && !stall_seen) begin
        stall_seen = 1; stall_pend = 1; hold_pc = ex_pc; hold_fa = imem_addr;
      end
      if (ld_we) begin
        chk(ld_waddr != 0, "R9", "load wb reg", int'(ld_waddr), 1);
        if (ld_waddr == 4)  t_ld4  = cyc;
        if (ld_waddr == 12) t_ld12 = cyc;
      end
      if (dmem_req && dmem_ready) hs++;
      if (chk_store) begin
        chk(dmem_req && dmem_we, "R10", "store request", int'(dmem_we), 1);
        chk_store = 0;
      end
      if (ex_issue && exp_q.size() != 0) begin
        pc = int'(ex_pc);
        e  = exp_q.pop_front();
        chk(pc == e, "R4", "issue order", pc, e);
        case (pc)
          0:  chk(rf_we && rf_waddr == 1, "R2", "alu wb r1", int'(rf_waddr), 1);
          1:  t1 = cyc;
          2:  begin
                chk(lock[4], "R5", "lock r4 set", int'(lock[4]), 1);
                chk(cyc == t1 + 1, "R6", "independent issue cycle", cyc, t1 + 1);
              end
          3:  begin
                t3 = cyc;
                chk(t_ld4 > 0 && cyc == t_ld4 + 1, "R8", "waw issue cycle", cyc, t_ld4 + 1);
              end
          4:  chk(cyc == t3 + 1, "R7", "reader after clear", cyc, t3 + 1);
          5:  t5 = cyc;
          6:  begin
                t6 = cyc;
                chk(cyc == t5 + 1, "R4", "delay slot cycle", cyc, t5 + 1);
              end
          10: chk(cyc == t6 + 1, "R4", "target cycle", cyc, t6 + 1);
          11: chk_store = 1;
          14: t14 = cyc;
          15: chk(cyc == t14 + 1 && lock == '0, "R9", "r0 reader no stall", cyc, t14 + 1);
          17: chk(!rf_we, "R9", "r0 alu write", int'(rf_we), 0);
          19: chk(t_ld12 > 0 && cyc == t_ld12 + 1, "R7", "store data interlock", cyc, t_ld12 + 1);
          default: ;
        endcase
      end
    end
  end

  initial begin
    int wd;
    for (int i = 0; i < 32; i++) prog[i] = '0;
    prog[0]  = enc(1, 1, 2, 3, 0);
    prog[1]  = enc(3, 4, 0, 0, 0);
    prog[2]  = enc(1, 5, 6, 7, 0);
    prog[3]  = enc(2, 4, 6, 0, 0);
    prog[4]  = enc(1, 8, 4, 1, 0);
    prog[5]  = enc(5, 0, 0, 0, 10);
    prog[6]  = enc(2, 9, 1, 0, 0);
    prog[7]  = enc(1, 31, 1, 1, 0);
    prog[10] = enc(6, 0, 1, 0, 14);
    prog[11] = enc(4, 0, 0, 5, 0);
    prog[12] = enc(1, 30, 1, 1, 0);
    prog[14] = enc(3, 0, 0, 0, 0);
    prog[15] = enc(1, 10, 0, 0, 0);
    prog[16] = enc(6, 0, 1, 0, 2);
    prog[17] = enc(1, 0, 1, 1, 0);
    prog[18] = enc(3, 12, 0, 0, 0);
    prog[19] = enc(4, 0, 0, 12, 0);
    prog[20] = enc(5, 0, 0, 0, 20);
    foreach (prog[i]) if (i >= 0 && i < 7) push_exp(i);
    push_exp(10); push_exp(11);
    for (int i = 14; i < 22; i++) push_exp(i);

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(imem_addr == 0 && !ex_issue, "R1", "reset fetch/issue", int'(imem_addr), 0);
    chk(lock == '0 && !dmem_req, "R1", "reset lock/req", int'(dmem_req), 0);
    rst_ni = 1'b1;

    wd = 0;
    while (exp_q.size() != 0 && wd < 2000) begin
      @(negedge clk);
      wd++;
    end
    chk(exp_q.size() == 0, "R3", "watchdog, issues left", exp_q.size(), 0);
    repeat (10) @(negedge clk);
    chk(hs == 5, "R10", "memory handshakes", hs, 5);
    chk(stall_seen, "R11", "stall observed", int'(stall_seen), 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule